// File: doc/BRIEF.md
# Pushbutton Power Control Sequencer

This block turns a single active-low pushbutton into power control. It counts how long the button has been held, using a millisecond tick, and acts at fixed hold lengths. When the system is off, a long enough hold raises the wake output, which starts power-up further down the line. When the system is on, each later press that lasts past a short threshold is copied onto an active-low status pin for the rest of that press. A very long hold forces a hard reset. Wake drops, a one-cycle regulator-disable command is issued, the processor reset is pulled low, and a lockout period follows in which the button is ignored.

The button input is synchronized inside the block, so it may arrive from a pad without a clock relation. All durations are parameters counted in ticks. A bench or a fast simulation can therefore run on a compressed time scale by driving the tick more often.

Top module: `pbctl_top`

## Requirements
- R1: Out of reset, wake is 0, pbstat_n is 1, rst_out_n is 1, reg_off is 0 and inhibit is 0.
- R2: In the off state, holding btn_n low for ON_MS (400) consecutive ticks sets wake to 1.
- R3: In the off state, a press shorter than ON_MS ticks has no effect. The hold count returns to zero on release, so short presses never add up.
- R4: In the on state, pbstat_n is 0 (active low) while the button is held and the current press has lasted at least STAT_MS (50) ticks. It returns to 1 one register stage after the synchronized release. This applies only to presses that start after the button has been released once since power-on.
- R5: A hold of HARD_MS (5000) ticks, counted from the start of the press, clears wake and pulses reg_off high for exactly one clock cycle.
- R6: On a hard reset, rst_out_n is driven low for RST_MS (1000) ticks.
- R7: For LOCK_MS (1000) ticks after a hard reset, inhibit is 1, wake stays 0, pbstat_n stays 1, and the button does not build up hold time.
- R8: When the lockout ends, the block is off. A button still held needs a fresh ON_MS ticks, counted from the end of the lockout, before wake rises again.
- R9: btn_n passes through a two-flop synchronizer. A change reaches the hold logic two clock cycles after it is sampled.
- R10: Hold and lockout time advance only in cycles where tick_ms is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| btn_n | input | 1 | Pushbutton, low when pressed |
| wake | output | 1 | High to start power-up |
| pbstat_n | output | 1 | Active-low mirror of a qualified press |
| rst_out_n | output | 1 | Active-low hard-reset indication to the processor |
| reg_off | output | 1 | One-cycle command to disable all regulators |
| inhibit | output | 1 | High during the post-reset lockout |

## Verification
A button edge sampled at clock edge k reaches the synchronized level at edge k+1. The hold count moves at edge k+2 on a tick cycle. Every output is registered, so each output responds one edge after the count or level that decides it. The bench reference model delays its button view through the same two edges and updates its outputs at the same edge, then compares all five outputs at every falling edge. Directed checks sample only well inside stable windows, tens of ticks after a threshold. The one exception is the single-cycle reg_off pulse, which is counted over the whole run rather than sampled.

// File: rtl/pbctl_pkg.sv
package pbctl_pkg;
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_ON   = 2'd1,
        PS_LOCK = 2'd2
    } pb_state_e;
endpackage

// File: rtl/pbctl_sync.sv
module pbctl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic pressed
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = ~btn_n;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pressed = s_q.s2;

    AST_SYNC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.s2) |-> $past(s_q.s1)); // R9
endmodule

// File: rtl/pbctl_hold_cnt.sv
module pbctl_hold_cnt #(
    parameter int HARD_MS = 5000,
    parameter int CW      = $clog2(HARD_MS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pressed,
    input  logic          clr,
    output logic [CW-1:0] hold
);
    localparam logic [CW-1:0] SAT = CW'(HARD_MS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!pressed || clr) begin
            h_d.cnt = '0;
        end else if (tick && h_q.cnt != SAT) begin
            h_d.cnt = h_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign hold = h_q.cnt;

    AST_HOLD_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !pressed |=> h_q.cnt == '0); // R3
    AST_HOLD_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && pressed && !clr) |=> $stable(h_q.cnt)); // R10
    AST_HOLD_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> h_q.cnt == '0); // R7
endmodule

// File: rtl/pbctl_fsm.sv
module pbctl_fsm
    import pbctl_pkg::*;
#(
    parameter int ON_MS   = 400,
    parameter int STAT_MS = 50,
    parameter int HARD_MS = 5000,
    parameter int RST_MS  = 1000,
    parameter int LOCK_MS = 1000,
    parameter int CW      = $clog2(HARD_MS + 1),
    parameter int LW      = $clog2(LOCK_MS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pressed,
    input  logic [CW-1:0] hold,
    output logic          wake,
    output logic          pbstat_n,
    output logic          rst_out_n,
    output logic          reg_off,
    output logic          inhibit
);
    localparam logic [CW-1:0] ON_C   = CW'(ON_MS);
    localparam logic [CW-1:0] STAT_C = CW'(STAT_MS);
    localparam logic [CW-1:0] HARD_C = CW'(HARD_MS);
    localparam logic [LW-1:0] RST_C  = LW'(RST_MS);
    localparam logic [LW-1:0] LOCK_C = LW'(LOCK_MS);

    typedef struct packed {
        pb_state_e     st;
        logic          armed;
        logic [LW-1:0] lock;
        logic          wake;
        logic          pbstat_n;
        logic          rst_n;
        logic          reg_off;
        logic          inhibit;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [LW-1:0] lock_inc;

    always_comb begin
        f_d         = f_q;
        f_d.reg_off = 1'b0;
        lock_inc    = f_q.lock + LW'(tick);
        unique case (f_q.st)
            PS_OFF: begin
                f_d.pbstat_n = 1'b1;
                if (hold >= ON_C) begin
                    f_d.st    = PS_ON;
                    f_d.wake  = 1'b1;
                    f_d.armed = 1'b0;
                end
            end
            PS_ON: begin
                f_d.armed    = f_q.armed | ~pressed;
                f_d.pbstat_n = ~(f_q.armed & pressed & (hold >= STAT_C));
                if (hold >= HARD_C) begin
                    f_d.st       = PS_LOCK;
                    f_d.wake     = 1'b0;
                    f_d.pbstat_n = 1'b1;
                    f_d.reg_off  = 1'b1;
                    f_d.rst_n    = 1'b0;
                    f_d.inhibit  = 1'b1;
                    f_d.lock     = '0;
                end
            end
            PS_LOCK: begin
                if (f_q.lock >= LOCK_C) begin
                    f_d.st      = PS_OFF;
                    f_d.inhibit = 1'b0;
                    f_d.rst_n   = 1'b1;
                    f_d.lock    = '0;
                end else begin
                    f_d.lock  = lock_inc;
                    f_d.rst_n = (lock_inc >= RST_C);
                end
            end
            default: begin
                f_d.st = PS_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q          <= '0;
            f_q.st       <= PS_OFF;
            f_q.pbstat_n <= 1'b1;
            f_q.rst_n    <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign wake      = f_q.wake;
    assign pbstat_n  = f_q.pbstat_n;
    assign rst_out_n = f_q.rst_n;
    assign reg_off   = f_q.reg_off;
    assign inhibit   = f_q.inhibit;

    AST_WAKE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.wake) |-> $past(hold) >= ON_C); // R2
    AST_REGOFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.reg_off |=> !f_q.reg_off); // R5
    AST_REGOFF_DROPS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.reg_off |-> !f_q.wake); // R5
    AST_RESET_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !f_q.rst_n |-> f_q.inhibit); // R6
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.inhibit |-> (!f_q.wake && f_q.pbstat_n)); // R7
    AST_PBSTAT_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !f_q.pbstat_n |-> f_q.wake); // R4
endmodule

// File: rtl/pbctl_top.sv
module pbctl_top #(
    parameter int ON_MS   = 400,
    parameter int STAT_MS = 50,
    parameter int HARD_MS = 5000,
    parameter int RST_MS  = 1000,
    parameter int LOCK_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic btn_n,
    output logic wake,
    output logic pbstat_n,
    output logic rst_out_n,
    output logic reg_off,
    output logic inhibit
);
    localparam int CW = $clog2(HARD_MS + 1);
    localparam int LW = $clog2(LOCK_MS + 1);

    logic          pressed;
    logic [CW-1:0] hold;
    logic          lock_clr;

    pbctl_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n   (btn_n),
        .pressed (pressed)
    );

    pbctl_hold_cnt #(.HARD_MS(HARD_MS), .CW(CW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .pressed (pressed),
        .clr     (lock_clr),
        .hold    (hold)
    );

    pbctl_fsm #(
        .ON_MS(ON_MS), .STAT_MS(STAT_MS), .HARD_MS(HARD_MS),
        .RST_MS(RST_MS), .LOCK_MS(LOCK_MS), .CW(CW), .LW(LW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .pressed   (pressed),
        .hold      (hold),
        .wake      (wake),
        .pbstat_n  (pbstat_n),
        .rst_out_n (rst_out_n),
        .reg_off   (reg_off),
        .inhibit   (lock_clr)
    );

    assign inhibit = lock_clr;
endmodule

// File: tb/sim_pbctl_top.sv
module sim_pbctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic btn_n = 1'b1;
    logic wake, pbstat_n, rst_out_n, reg_off, inhibit;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int regoff_cnt = 0;
    bit done   = 1'b0;

    pbctl_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
        .wake(wake), .pbstat_n(pbstat_n), .rst_out_n(rst_out_n),
        .reg_off(reg_off), .inhibit(inhibit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc++;
        tick_ms = (cyc % TDIV) == 0;
    end

    // Behavioural reference: button seen two edges late (R9), time moves on ticks (R10)
    bit m_s1, m_p, m_armed, m_w, m_pb, m_rst, m_reg, m_inh;
    int m_hold, m_lock, m_mode;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_p = 0; m_hold = 0; m_lock = 0; m_mode = 0; m_armed = 0;
            m_w = 0; m_pb = 1; m_rst = 1; m_reg = 0; m_inh = 0;
        end else begin
            automatic bit p_old = m_p;
            automatic int h_old = m_hold;
            automatic int mode_next = m_mode;
            m_p  = m_s1;
            m_s1 = !btn_n;
            m_hold = (!p_old || m_mode == 2) ? 0 :
                     ((tick_ms && h_old < 5000) ? h_old + 1 : h_old);
            m_reg = 0;
            if (m_mode == 0) begin
                m_pb = 1;
                if (h_old >= 400) begin mode_next = 1; m_w = 1; m_armed = 0; end
            end else if (m_mode == 1) begin
                m_pb = !(m_armed && p_old && h_old >= 50);
                if (!p_old) m_armed = 1;
                if (h_old >= 5000) begin
                    mode_next = 2; m_w = 0; m_pb = 1; m_reg = 1; m_rst = 0; m_inh = 1; m_lock = 0;
                end
            end else begin
                if (m_lock >= 1000) begin
                    mode_next = 0; m_inh = 0; m_rst = 1; m_lock = 0;
                end else begin
                    m_lock = m_lock + (tick_ms ? 1 : 0);
                    m_rst = m_lock >= 1000;
                end
            end
            m_mode = mode_next;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reg_off === 1'b1) regoff_cnt++;
            chk("R2 R8 R9 R10 wake vs model", wake, m_w);
            chk("R4 R9 pbstat_n vs model", pbstat_n, m_pb);
            chk("R6 rst_out_n vs model", rst_out_n, m_rst);
            chk("R5 reg_off vs model", reg_off, m_reg);
            chk("R7 inhibit vs model", inhibit, m_inh);
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wake", wake, 1'b0);
        chk("R1 pbstat_n", pbstat_n, 1'b1);
        chk("R1 rst_out_n", rst_out_n, 1'b1);
        chk("R1 reg_off", reg_off, 1'b0);
        chk("R1 inhibit", inhibit, 1'b0);

        // R3: two short presses do not accumulate
        btn_n = 0; wait_ticks(300); btn_n = 1; wait_ticks(20);
        btn_n = 0; wait_ticks(300); btn_n = 1; wait_ticks(20);
        chk("R3 short presses", wake, 1'b0);

        // R2: full hold powers on; R4: power-on press not mirrored
        btn_n = 0; wait_ticks(410);
        chk("R2 wake after hold", wake, 1'b1);
        chk("R4 power-on press not mirrored", pbstat_n, 1'b1);
        btn_n = 1; wait_ticks(20);

        // R4: short press under threshold, then a qualified press
        btn_n = 0; wait_ticks(30);
        chk("R4 under threshold", pbstat_n, 1'b1);
        btn_n = 1; wait_ticks(20);
        btn_n = 0; wait_ticks(80);
        chk("R4 mirrored press", pbstat_n, 1'b0);
        btn_n = 1; repeat (5) @(negedge clk);
        chk("R4 release", pbstat_n, 1'b1);
        chk("R4 still on", wake, 1'b1);
        wait_ticks(20);

        // R5 R6 R7: hard reset and lockout
        btn_n = 0; wait_ticks(5050);
        chk("R5 wake dropped", wake, 1'b0);
        chk("R6 reset low", rst_out_n, 1'b0);
        chk("R7 inhibit high", inhibit, 1'b1);
        chk("R7 button ignored", pbstat_n, 1'b1);
        wait_ticks(940);
        chk("R6 reset still low", rst_out_n, 1'b0);
        chk("R7 still locked", inhibit, 1'b1);

        // R8: lockout over, fresh hold needed
        wait_ticks(30);
        chk("R8 lock released", inhibit, 1'b0);
        chk("R6 reset released", rst_out_n, 1'b1);
        chk("R8 off after lock", wake, 1'b0);
        wait_ticks(300);
        chk("R8 no early wake", wake, 1'b0);
        wait_ticks(120);
        chk("R8 fresh hold wakes", wake, 1'b1);
        btn_n = 1; wait_ticks(10);

        checks++;
        if (regoff_cnt != 1) begin
            fails++;
            $display("FAIL R5 reg_off pulse cycles actual=%0d expected=1", regoff_cnt);
        end
        finish_run();
    end
endmodule